// File: doc/BRIEF.md
# Multi-Channel Programmable Clock Output Divider

This block produces three divided square-wave clocks from two shared source references: a low-rate reference at 32768 Hz and a high-rate reference near 4 MHz. Both references reach the block as single-cycle tick pulses in one fast system clock domain, so every divider is a plain synchronous counter. Each output channel has its own 8-bit control register that gates the channel, picks one of the two sources, and sets two division stages. The first stage is a coarse prescaler that acts only on the high-rate source and follows a near-binary ratio table. The second stage is a binary postscaler.

Software reaches the three control registers through a small synchronous write port with a combinational read path, at addresses 0, 1 and 2. Each channel toggles its output once every half of its total ratio in source ticks. Every even total ratio therefore gives a 50% duty cycle. A total ratio of one passes the source tick pulse straight out. When a channel's division settings change, the channel restarts from a clean low level, so no shortened pulse appears on the pin.

Top module: `divclk_bank`

## Requirements
- R1: Channel control registers sit at addresses 0, 1 and 2, and read back exactly the last byte written. Address 3 reads as 0x00, and a write to it changes no register.
- R2: While rst_n is low at a clock edge, all three registers clear to 0x00 and all outputs are low.
- R3: Register bit 0 is the channel enable. While it is 0, the channel output is low from the cycle after the register holds that value.
- R4: Register bit 4 picks the source. A 0 counts lo_tick pulses and a 1 counts hi_tick pulses.
- R5: With the high-rate source, register bits 7:5 choose a prescale ratio. Codes 0 to 6 give 2^code, and code 7 gives 122.
- R6: With the low-rate source, bits 7:5 have no effect on the output period.
- R7: Register bits 3:1 give a postscale ratio of 2^code, that is 1 to 128. The total ratio is the prescale ratio times the postscale ratio.
- R8: For a total ratio N greater than 1, the output first rises on the (N/2)-th selected tick after the channel starts or restarts. It then toggles on every further N/2 ticks, each toggle appearing in the cycle after the edge that samples the tick.
- R9: For a total ratio of 1, the output is high in exactly the cycles that follow an edge at which the selected tick was high.
- R10: A write that changes bits 7:1 of a channel's register clears that channel's counter and drives its output low in the following cycle, whatever the output was before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lo_tick | input | 1 | One-cycle pulse per low-rate source period |
| hi_tick | input | 1 | One-cycle pulse per high-rate source period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for writes and reads |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for addr (combinational) |
| clk_out | output | 3 | Divided clock outputs, bit i for channel i |

## Verification
The bench measures each half period in selected source ticks. It targets the 122 prescale entry on its own and combined with the largest postscale, where a design that used 128 would stretch every half period. It switches the prescale field while the low-rate source is active; a design that failed to bypass the prescaler would lengthen the period. It also changes the configuration while an output is high; a design without restart would leave the level high or emit a runt first interval. Further cases cover ratio-one pass-through, which a toggling design would halve, and a clear of the enable alone, which must silence the pin without a restart.

// File: rtl/divclk_pkg.sv
package divclk_pkg;

  localparam int PRE_W         = 3;
  localparam int POST_W        = 3;
  localparam int PRE_TOP_RATIO = 122;
  localparam int MAX_TOTAL     = PRE_TOP_RATIO << ((1 << POST_W) - 1);
  localparam int CNT_W         = $clog2(MAX_TOTAL / 2);
  localparam int TOT_W         = CNT_W + 1;

  typedef logic [TOT_W-1:0] total_t;
  typedef logic [CNT_W-1:0] half_t;

  // Field order is fixed by the register layout seen by software.
  typedef struct packed {
    logic [PRE_W-1:0]  pre;
    logic              src_hi;
    logic [POST_W-1:0] post;
    logic              en;
  } chan_ctl_t;

  // Prescale ratio: binary steps, except the top code which is 122.
  function automatic total_t pre_ratio(input logic [PRE_W-1:0] code);
    if (code == '1) return total_t'(PRE_TOP_RATIO);
    return total_t'(1) << code;
  endfunction

  // Source ticks between output toggles; zero means pass-through.
  function automatic half_t half_ticks(input chan_ctl_t c);
    total_t total;
    total = c.src_hi ? (pre_ratio(c.pre) << c.post) : (total_t'(1) << c.post);
    return total[TOT_W-1:1];
  endfunction

endpackage

// File: rtl/divclk_regs.sv
module divclk_regs
  import divclk_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [7:0]               wdata,
  output logic [7:0]               rdata,
  output chan_ctl_t [NUM_CH-1:0]   ctl_o,
  output logic [NUM_CH-1:0]        restart_o
);

  logic [NUM_CH-1:0] hit;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      hit[i]       = wr_en && (addr == ADDR_W'(i));
      // Only a change to the division or source fields forces a restart.
      restart_o[i] = hit[i] && (wdata[7:1] != ctl_o[i][7:1]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_o <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (hit[i]) ctl_o[i] <= chan_ctl_t'(wdata);
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) rdata = ctl_o[i];
    end
  end

  // R1: a write in range lands in the addressed register
  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(addr) < NUM_CH)) |=> (ctl_o[$past(addr)] == $past(wdata)));

  // R1: a write outside the register range leaves every register alone
  a_r1_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(addr) >= NUM_CH)) |=> $stable(ctl_o));

endmodule

// File: rtl/divclk_chan.sv
module divclk_chan
  import divclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lo_tick,
  input  logic      hi_tick,
  input  chan_ctl_t ctl,
  input  logic      restart,
  output logic      out_o
);

  logic  tick_sel;
  half_t half;
  logic  pass_mode;
  logic  wrap;
  half_t cnt;

  assign tick_sel  = ctl.src_hi ? hi_tick : lo_tick;
  assign half      = half_ticks(ctl);
  assign pass_mode = (half == '0);
  assign wrap      = tick_sel && (cnt == half - half_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !ctl.en || restart) begin
      cnt   <= '0;
      out_o <= 1'b0;
    end else if (pass_mode) begin
      cnt   <= '0;
      out_o <= tick_sel;
    end else if (wrap) begin
      cnt   <= '0;
      out_o <= ~out_o;
    end else if (tick_sel) begin
      cnt   <= cnt + half_t'(1);
    end
  end

  // R3: a disabled channel is silent on the next cycle
  a_r3_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |=> !out_o);

  // R10: a configuration change drives the output low
  a_r10_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !out_o);

  // R8: the tick counter never reaches the half period
  a_r8_cnt_below_half: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.en && !pass_mode) |-> (cnt < half));

  // R8: a running divider only changes level on a selected tick
  a_r8_toggle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_o != $past(out_o)) && $past(ctl.en) && !$past(restart) && !$past(pass_mode))
      |-> $past(tick_sel));

  // R9: ratio one follows the selected tick one cycle later
  a_r9_pass_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pass_mode) && $past(ctl.en) && !$past(restart)) |-> (out_o == $past(tick_sel)));

endmodule

// File: rtl/divclk_bank.sv
module divclk_bank
  import divclk_pkg::*;
#(
  parameter  int NUM_CH = 3,
  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_tick,
  input  logic              hi_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [NUM_CH-1:0] clk_out
);

  chan_ctl_t [NUM_CH-1:0] ctl;
  logic [NUM_CH-1:0]      restart;

  divclk_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .ctl_o     (ctl),
    .restart_o (restart)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    divclk_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_tick (lo_tick),
      .hi_tick (hi_tick),
      .ctl     (ctl[g]),
      .restart (restart[g]),
      .out_o   (clk_out[g])
    );
  end

endmodule

// File: tb/sim_divclk_bank.sv
module sim_divclk_bank;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lo_tick = 1'b0;
  logic       hi_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] clk_out;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  int mon_ch = 0;
  bit mon_on = 1'b0;
  bit mon_src = 1'b0;

  always #2 clk = ~clk;

  divclk_bank u0 (
    .clk(clk), .rst_n(rst_n), .lo_tick(lo_tick), .hi_tick(hi_tick),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .clk_out(clk_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected half period built by repeated doubling from the requirements.
  function automatic int exp_half(input logic [7:0] c);
    int r = 1;
    for (int k = 0; k < int'(c[3:1]); k++) r = r * 2;
    if (c[4]) begin
      int p = 1;
      if (c[7:5] == 3'd7) p = 122;
      else for (int k = 0; k < int'(c[7:5]); k++) p = p * 2;
      r = r * p;
    end
    return r / 2;
  endfunction

  // Tick sources: low rate every 3 cycles, high rate every 2 cycles.
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk); #1;
      ph++;
      lo_tick = (ph % 3 == 0);
      hi_tick = (ph % 2 == 0);
    end
  end

  // Monitor: counts selected ticks and compares each toggle interval.
  initial begin
    logic [7:0] shadow [3];
    logic [2:0] prev = '0;
    bit   p_wr = 0;
    logic [1:0] p_addr = '0;
    logic [7:0] p_wdata = '0;
    bit   p_tick = 0;
    int   cnt = 0;
    for (int i = 0; i < 3; i++) shadow[i] = '0;
    forever begin
      bit restarted;
      @(negedge clk);
      restarted = 0;
      if (p_wr && p_addr < 2'd3) begin
        bit chg;
        chg = (shadow[p_addr][7:1] != p_wdata[7:1]);
        shadow[p_addr] = p_wdata;
        if (chg && mon_on && int'(p_addr) == mon_ch) begin
          restarted = 1;
          cnt = 0;
          check(clk_out[mon_ch] == 1'b0, "R10 output low after restart", int'(clk_out[mon_ch]), 0);
          prev[mon_ch] = 1'b0;
        end
      end
      if (!restarted && p_tick) cnt++;
      if (mon_on && !restarted && clk_out[mon_ch] != prev[mon_ch]) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected toggle", cnt, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(cnt == e, "R8 half period in ticks", cnt, e);
        end
        cnt = 0;
      end
      prev    = clk_out;
      p_wr    = wr_en;
      p_addr  = addr;
      p_wdata = wdata;
      p_tick  = mon_src ? hi_tick : lo_tick;
    end
  end

  task automatic reg_write(input int a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = 2'(a); wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input int a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    addr = 2'(a);
    @(negedge clk);
    check(rdata == exp, tag, int'(rdata), int'(exp));
  endtask

  task automatic run_case(input int ch, input logic [7:0] cfg, input int n, input int rate);
    int e;
    int k = 0;
    e = exp_half(cfg);
    mon_ch = ch;
    mon_src = cfg[4];
    for (int i = 0; i < n; i++) exp_q.push_back(e);
    mon_on = 1'b1;
    reg_write(ch, cfg);
    while (exp_q.size() != 0 && k < e * rate * n + 100) begin
      @(posedge clk);
      k++;
    end
    check(exp_q.size() == 0, "R8 all expected toggles seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic stop_case(input int ch);
    mon_on = 1'b0;
    reg_write(ch, 8'h00);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(clk_out == 3'b000, "R2 outputs low after reset", int'(clk_out), 0);
    reg_read(0, 8'h00, "R2 reg0 cleared");
    reg_read(1, 8'h00, "R2 reg1 cleared");
    reg_read(2, 8'h00, "R2 reg2 cleared");

    // R1: readback and the unused address
    reg_write(0, 8'hA4);
    reg_write(1, 8'h3A);
    reg_write(2, 8'hE2);
    reg_read(0, 8'hA4, "R1 reg0 readback");
    reg_read(1, 8'h3A, "R1 reg1 readback");
    reg_read(2, 8'hE2, "R1 reg2 readback");
    reg_write(3, 8'h5B);
    reg_read(3, 8'h00, "R1 address 3 reads zero");
    reg_read(0, 8'hA4, "R1 reg0 untouched by address 3");
    reg_read(1, 8'h3A, "R1 reg1 untouched by address 3");
    reg_read(2, 8'hE2, "R1 reg2 untouched by address 3");
    for (int i = 0; i < 3; i++) reg_write(i, 8'h00);

    // R4 R7: low-rate source, postscale 8, half period 4
    run_case(0, 8'h07, 4, 3);
    // R6 R10: prescale field set to 7 under low-rate source, same period
    run_case(0, 8'hE7, 4, 3);
    stop_case(0);
    // R5: high-rate source, prescale code 7 (122), no postscale
    run_case(1, 8'hF1, 3, 2);
    stop_case(1);
    // R5 R7: prescale 4, postscale 4
    run_case(2, 8'h55, 4, 2);
    stop_case(2);
    // R5 R7: largest total ratio 122*128
    run_case(0, 8'hFF, 2, 2);
    stop_case(0);
    // R7: low-rate source, postscale 128
    run_case(2, 8'h0F, 3, 3);
    stop_case(2);
    // R4: high-rate source, total ratio 2
    run_case(1, 8'h13, 6, 2);

    // R3: clear only the enable, output must stay low
    mon_on = 1'b0;
    reg_write(1, 8'h12);
    @(negedge clk);
    begin
      int bad = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (clk_out[1] != 1'b0) bad++;
      end
      check(bad == 0, "R3 disabled channel held low", bad, 0);
    end
    reg_write(1, 8'h00);

    // R9: total ratio one on the low-rate source
    reg_write(1, 8'h01);
    begin
      int bad = 0;
      int highs = 0;
      bit last;
      @(negedge clk);
      last = lo_tick;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (clk_out[1] != last) bad++;
        if (clk_out[1]) highs++;
        last = lo_tick;
      end
      check(bad == 0, "R9 pass-through follows tick", bad, 0);
      check(highs == 10, "R9 one high cycle per tick", highs, 10);
    end
    reg_write(1, 8'h00);

    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule